// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds wall-clock time and calendar date as six binary fields: second, minute, hour, day, month and year. The year is an offset from a base year, 2000 by default. It runs in the slow real-time clock domain. Each one-cycle `tick` advances the count by one second. A prescaler outside the block produces that tick by dividing the 32.768 kHz source by 32768. Carries run from seconds through to years. Day rollover follows the length of the current month, and February follows the leap-year rule.

Software or a bus bridge can overwrite every field at once through a synchronous load port. Counting then continues from the written value. The block also publishes all six fields packed into one 32-bit word, so a bus register can read them as a single snapshot.

Top module: `calendarCounter`

## Requirements
- R1: Each cycle with `tick` high and `loadEn` low advances the second by one. From 59 the second returns to 0.
- R2: A second wrap increments the minute. From 59 the minute returns to 0.
- R3: A minute wrap increments the hour. From 23 the hour returns to 0.
- R4: An hour wrap increments the day. The day returns to 1 and the month increments past day 30 for months 4, 6, 9 and 11, and past day 31 for months 1, 3, 5, 7, 8, 10 and 12.
- R5: In February the last day is 29 when the full year (base + offset) is divisible by 4 and not by 100, or is divisible by 400. Otherwise the last day is 28.
- R6: After month 12 the month returns to 1 and the year offset increments. The offset wraps from 63 to 0.
- R7: While `rstN` is low the fields read 00:00:00, day 1, month 1, year offset 17.
- R8: A cycle with `loadEn` high sets every field to the load inputs at the next edge. Later ticks count on from those values.
- R9: When `loadEn` and `tick` are high in the same cycle, the loaded values appear unchanged and the tick is dropped.
- R10: `snapshot` is {year[31:26], month[25:22], day[21:17], hour[16:12], minute[11:6], second[5:0]}.
- R11: With `tick` and `loadEn` both low, no field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Real-time clock domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance strobe, one cycle wide |
| loadEn | input | 1 | Overwrite all fields with the load inputs |
| loadSec | input | 6 | Second to load |
| loadMin | input | 6 | Minute to load |
| loadHour | input | 5 | Hour to load |
| loadDay | input | 5 | Day of month to load |
| loadMon | input | 4 | Month to load (1 to 12) |
| loadYear | input | 6 | Year offset to load |
| sec | output | 6 | Current second |
| min | output | 6 | Current minute |
| hour | output | 5 | Current hour |
| day | output | 5 | Current day of month |
| mon | output | 4 | Current month |
| year | output | 6 | Current year offset |
| snapshot | output | 32 | Packed time and date |

## Verification
The hardest cases to reach are the month-end and year-end carries. From reset they sit tens of millions of ticks away, and only the last second of a month exercises the day-length and leap-year logic. The stimulus reaches them by loading the state two seconds before midnight on the last day of every month, in a plain year, a leap year, the base year 2000 (divisible by 400) and the final year offset, and then applying a few ticks. A bench model written from the calendar rules is compared with every output on every clock. This includes a load issued in the same cycle as a tick, and runs of idle cycles between ticks.

// File: rtl/calPkg.sv
package calPkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;

  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;
  localparam int MON_LAST  = 12;

  typedef struct packed {
    logic load;
    logic stepSec;
    logic stepMin;
    logic stepHour;
    logic stepDay;
    logic stepMon;
    logic stepYear;
    logic wrapSec;
    logic wrapMin;
    logic wrapHour;
    logic wrapDay;
    logic wrapMon;
  } calStrobeT;
endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
#(
  parameter int YEAR_W    = 6,
  parameter int BASE_YEAR = 2000
) (
  input  logic               tick,
  input  logic               loadEn,
  input  logic [SEC_W-1:0]   secQ,
  input  logic [MIN_W-1:0]   minQ,
  input  logic [HOUR_W-1:0]  hourQ,
  input  logic [DAY_W-1:0]   dayQ,
  input  logic [MON_W-1:0]   monQ,
  input  logic [YEAR_W-1:0]  yearQ,
  output calStrobeT          st
);
  logic              isLeap;
  logic [DAY_W-1:0]  lastDay;
  logic secEnd, minEnd, hourEnd, dayEnd, monEnd;

  // leap-year rule applied to the full year number
  always_comb begin
    int fullYear;
    fullYear = BASE_YEAR + int'(yearQ);
    isLeap = ((fullYear % 4 == 0) && (fullYear % 100 != 0)) || (fullYear % 400 == 0);
  end

  always_comb begin
    case (monQ)
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): lastDay = DAY_W'(30);
      MON_W'(2):                                   lastDay = isLeap ? DAY_W'(29) : DAY_W'(28);
      default:                                     lastDay = DAY_W'(31);
    endcase
  end

  // ">=" so that an out-of-range loaded value still rolls over
  assign secEnd  = secQ  >= SEC_W'(SEC_LAST);
  assign minEnd  = minQ  >= MIN_W'(MIN_LAST);
  assign hourEnd = hourQ >= HOUR_W'(HOUR_LAST);
  assign dayEnd  = dayQ  >= lastDay;
  assign monEnd  = monQ  >= MON_W'(MON_LAST);

  // carry chain; a load suppresses every step
  always_comb begin
    st          = '0;
    st.load     = loadEn;
    st.stepSec  = tick & ~loadEn;
    st.wrapSec  = st.stepSec & secEnd;
    st.stepMin  = st.wrapSec;
    st.wrapMin  = st.stepMin & minEnd;
    st.stepHour = st.wrapMin;
    st.wrapHour = st.stepHour & hourEnd;
    st.stepDay  = st.wrapHour;
    st.wrapDay  = st.stepDay & dayEnd;
    st.stepMon  = st.wrapDay;
    st.wrapMon  = st.stepMon & monEnd;
    st.stepYear = st.wrapMon;
  end
endmodule

// File: rtl/calData.sv
module calData
  import calPkg::*;
#(
  parameter int YEAR_W         = 6,
  parameter int RESET_YEAR_OFS = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  calStrobeT          st,
  input  logic [SEC_W-1:0]   loadSec,
  input  logic [MIN_W-1:0]   loadMin,
  input  logic [HOUR_W-1:0]  loadHour,
  input  logic [DAY_W-1:0]   loadDay,
  input  logic [MON_W-1:0]   loadMon,
  input  logic [YEAR_W-1:0]  loadYear,
  output logic [SEC_W-1:0]   secQ,
  output logic [MIN_W-1:0]   minQ,
  output logic [HOUR_W-1:0]  hourQ,
  output logic [DAY_W-1:0]   dayQ,
  output logic [MON_W-1:0]   monQ,
  output logic [YEAR_W-1:0]  yearQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ  <= '0;
      minQ  <= '0;
      hourQ <= '0;
      dayQ  <= DAY_W'(1);
      monQ  <= MON_W'(1);
      yearQ <= YEAR_W'(RESET_YEAR_OFS);
    end else if (st.load) begin
      secQ  <= loadSec;
      minQ  <= loadMin;
      hourQ <= loadHour;
      dayQ  <= loadDay;
      monQ  <= loadMon;
      yearQ <= loadYear;
    end else begin
      if (st.stepSec)  secQ  <= st.wrapSec  ? '0         : secQ  + 1'b1;
      if (st.stepMin)  minQ  <= st.wrapMin  ? '0         : minQ  + 1'b1;
      if (st.stepHour) hourQ <= st.wrapHour ? '0         : hourQ + 1'b1;
      if (st.stepDay)  dayQ  <= st.wrapDay  ? DAY_W'(1)  : dayQ  + 1'b1;
      if (st.stepMon)  monQ  <= st.wrapMon  ? MON_W'(1)  : monQ  + 1'b1;
      if (st.stepYear) yearQ <= yearQ + 1'b1;
    end
  end

  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (st.stepSec && secQ == SEC_W'(SEC_LAST)) |=> secQ == '0);

  p_hour_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st.stepHour && hourQ == HOUR_W'(HOUR_LAST)) |=> hourQ == '0);

  p_day_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.wrapDay |=> dayQ == DAY_W'(1));

  p_year_carry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.stepMon && monQ == MON_W'(MON_LAST)) |=>
      (monQ == MON_W'(1) && yearQ == YEAR_W'($past(yearQ) + 1'b1)));

  p_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.load |=> (secQ == $past(loadSec) && minQ == $past(loadMin) &&
                 hourQ == $past(loadHour) && dayQ == $past(loadDay) &&
                 monQ == $past(loadMon) && yearQ == $past(loadYear)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!st.load && !st.stepSec) |=> ($stable(secQ) && $stable(minQ) && $stable(hourQ) &&
                                   $stable(dayQ) && $stable(monQ) && $stable(yearQ)));
endmodule

// File: rtl/calendarCounter.sv
module calendarCounter
  import calPkg::*;
#(
  parameter int YEAR_W         = 6,
  parameter int BASE_YEAR      = 2000,
  parameter int RESET_YEAR_OFS = 17,
  localparam int SNAP_W        = YEAR_W + MON_W + DAY_W + HOUR_W + MIN_W + SEC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               loadEn,
  input  logic [SEC_W-1:0]   loadSec,
  input  logic [MIN_W-1:0]   loadMin,
  input  logic [HOUR_W-1:0]  loadHour,
  input  logic [DAY_W-1:0]   loadDay,
  input  logic [MON_W-1:0]   loadMon,
  input  logic [YEAR_W-1:0]  loadYear,
  output logic [SEC_W-1:0]   sec,
  output logic [MIN_W-1:0]   min,
  output logic [HOUR_W-1:0]  hour,
  output logic [DAY_W-1:0]   day,
  output logic [MON_W-1:0]   mon,
  output logic [YEAR_W-1:0]  year,
  output logic [SNAP_W-1:0]  snapshot
);
  calStrobeT strobes;

  calCtrl #(.YEAR_W(YEAR_W), .BASE_YEAR(BASE_YEAR)) uCtrl (
    .tick(tick), .loadEn(loadEn),
    .secQ(sec), .minQ(min), .hourQ(hour), .dayQ(day), .monQ(mon), .yearQ(year),
    .st(strobes)
  );

  calData #(.YEAR_W(YEAR_W), .RESET_YEAR_OFS(RESET_YEAR_OFS)) uData (
    .clk(clk), .rstN(rstN), .st(strobes),
    .loadSec(loadSec), .loadMin(loadMin), .loadHour(loadHour),
    .loadDay(loadDay), .loadMon(loadMon), .loadYear(loadYear),
    .secQ(sec), .minQ(min), .hourQ(hour), .dayQ(day), .monQ(mon), .yearQ(year)
  );

  // R10 packing order
  assign snapshot = {year, mon, day, hour, min, sec};
endmodule

// File: tb/tb_calendarCounter.sv
module tb_calendarCounter;
  localparam int BASE = 2000;

  logic clk = 1'b0;
  logic rstN;
  logic tick, loadEn;
  logic [5:0] loadSec, loadMin, loadYear;
  logic [4:0] loadHour, loadDay;
  logic [3:0] loadMon;
  logic [5:0] sec, min, year;
  logic [4:0] hour, day;
  logic [3:0] mon;
  logic [31:0] snapshot;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  int mS, mMi, mH, mD, mMo, mY;

  always #10 clk = ~clk;

  calendarCounter dut (
    .clk(clk), .rstN(rstN), .tick(tick), .loadEn(loadEn),
    .loadSec(loadSec), .loadMin(loadMin), .loadHour(loadHour),
    .loadDay(loadDay), .loadMon(loadMon), .loadYear(loadYear),
    .sec(sec), .min(min), .hour(hour), .day(day), .mon(mon), .year(year),
    .snapshot(snapshot)
  );

  function automatic int monthLen(int m, int yOfs);
    int fy;
    bit lp;
    fy = BASE + yOfs;
    lp = ((fy % 4 == 0) && (fy % 100 != 0)) || (fy % 400 == 0);
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic modelStep(bit t, bit ld, int s, int mi, int h, int d, int mo, int y);
    if (ld) begin
      mS = s; mMi = mi; mH = h; mD = d; mMo = mo; mY = y;
    end else if (t) begin
      mS++;
      if (mS == 60) begin
        mS = 0; mMi++;
        if (mMi == 60) begin
          mMi = 0; mH++;
          if (mH == 24) begin
            mH = 0; mD++;
            if (mD > monthLen(mMo, mY)) begin
              mD = 1; mMo++;
              if (mMo == 13) begin
                mMo = 1; mY = (mY + 1) % 64;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic chk(string tag, string name, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    logic [31:0] expSnap;
    vectors++;
    expSnap = {mY[5:0], mMo[3:0], mD[4:0], mH[4:0], mMi[5:0], mS[5:0]};
    chk(tag, "sec",  int'(sec),  mS);
    chk(tag, "min",  int'(min),  mMi);
    chk(tag, "hour", int'(hour), mH);
    chk(tag, "day",  int'(day),  mD);
    chk(tag, "mon",  int'(mon),  mMo);
    chk(tag, "year", int'(year), mY);
    if (snapshot !== expSnap) begin
      errors++;
      $display("FAIL R10 snapshot actual=%h expected=%h (%s)", snapshot, expSnap, tag);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at the next negedge
  task automatic cyc(string tag, bit t, bit ld = 0,
                     int s = 0, int mi = 0, int h = 0, int d = 1, int mo = 1, int y = 0);
    tick = t; loadEn = ld;
    loadSec = 6'(s); loadMin = 6'(mi); loadHour = 5'(h);
    loadDay = 5'(d); loadMon = 4'(mo); loadYear = 6'(y);
    @(posedge clk);
    modelStep(t, ld, s, mi, h, d, mo, y);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic monthEnd(string tag, int mo, int y);
    cyc(tag, 0, 1, 58, 59, 23, monthLen(mo, y), mo, y);
    for (int i = 0; i < 3; i++) cyc(tag, 1);
  endtask

  initial begin
    rstN = 1'b0; tick = 0; loadEn = 0;
    loadSec = '0; loadMin = '0; loadHour = '0; loadDay = '0; loadMon = '0; loadYear = '0;
    mS = 0; mMi = 0; mH = 0; mD = 1; mMo = 1; mY = 17;
    repeat (3) @(negedge clk);
    compareAll("R7 reset");
    tick = 1;
    @(negedge clk);
    compareAll("R7 reset holds against tick");
    tick = 0;
    rstN = 1'b1;

    // R1 R2 R11: ticks with idle gaps, across several minute carries
    for (int i = 0; i < 200; i++) cyc("R1 R2 R11 run", (i % 3) != 1);
    // R3 hour wrap and R2 via 23:59:58
    cyc("R8 load", 0, 1, 57, 59, 22, 10, 5, 30);
    for (int i = 0; i < 4; i++) cyc("R3 hour carry", 1);
    cyc("R8 load", 0, 1, 58, 59, 23, 10, 5, 30);
    for (int i = 0; i < 4; i++) cyc("R3 day carry", 1);
    // R4 every month end, plain year 2023
    for (int m = 1; m <= 12; m++) monthEnd("R4 month end 2023", m, 23);
    // R5 leap Feb 2024, non-leap probe at day 28, base year 2000
    monthEnd("R5 Feb 2024", 2, 24);
    cyc("R5 load Feb28 2024", 0, 1, 59, 59, 23, 28, 2, 24);
    cyc("R5 Feb28->29 2024", 1);
    cyc("R5 load Feb28 2023", 0, 1, 59, 59, 23, 28, 2, 23);
    cyc("R5 Feb28->Mar1 2023", 1);
    cyc("R5 load Feb28 2000", 0, 1, 59, 59, 23, 28, 2, 0);
    cyc("R5 Feb28->29 2000", 1);
    monthEnd("R5 Feb 2000", 2, 0);
    // R6 year carry and offset wrap
    monthEnd("R6 Dec 2017", 12, 17);
    monthEnd("R6 Dec offset 63", 12, 63);
    // R9 load wins over tick
    cyc("R9 load with tick", 1, 1, 59, 59, 23, 31, 12, 40);
    cyc("R9 hold after", 0);
    cyc("R8 continue", 1);
    for (int i = 0; i < 20; i++) cyc("R11 idle", 0);
    for (int i = 0; i < 70; i++) cyc("R1 tail", 1);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule